// File: doc/BRIEF.md
# Write-Back Data Cache Controller with Runtime Cache Disable

This block is a small write-back, write-allocate data cache. It holds 16 sets of two 64-byte lines each. Every line carries a five-state coherence code (invalid, shared, exclusive, owned, modified). The owned and modified states count as dirty. One LRU bit per set picks the victim when both ways of a set are valid. A processor issues single-word loads and stores on one request port. Whole-line fills and write-backs, and single-word uncached accesses, go out on one memory port with a request/acknowledge handshake.

A level input, `cache_dis`, switches the cache off at run time without losing data:

- **Lookups with the input set:** a lookup that hits first writes a dirty line back and then invalidates it. After that, the access is carried out as a single-word uncached read or write. Lookups that miss go straight to memory and never allocate, so the array only ever loses lines in this mode.
- **Probes:** coherence probes arriving on the probe port are still served in both modes. A dirty hit is written back. The line is dropped only when the probe says the requester wants to write or to own the line. Otherwise the line stays valid and clean.
- **Flush:** a flush command walks every line, writes back the dirty ones, leaves the whole array invalid and then pulses a done flag.

Top module: `nofill_dcache`

## Requirements
- R1: With `cache_dis` low, a load or store that hits a valid line completes with `cpu_ack` and no memory transaction. A load returns the latest value stored to that word, and a store makes the line dirty.
- R2: With `cache_dis` low, a miss allocates a line. If the chosen victim is dirty, it is first written back as a line write (`mem_line`=1, `mem_we`=1) with its latest contents. The missing line is then read as a line read (`mem_line`=1, `mem_we`=0). A store miss merges its word into the filled line and leaves it dirty.
- R3: The victim is an invalid way when the set has one. Otherwise it is the way not used most recently by a processor hit or fill.
- R4: With `cache_dis` high, a hit to a dirty line issues a line write-back of that line. It then issues one word access (`mem_line`=0, `mem_we`=`cpu_we`, address = `cpu_addr`, store data in `mem_wdata[31:0]`, load data taken from `mem_rdata[31:0]`). Afterwards the line is no longer resident.
- R5: With `cache_dis` high, a hit to a clean line issues no write-back, invalidates the line and performs the single word access.
- R6: With `cache_dis` high, a miss performs only the single word access, and no line is ever filled.
- R7: A probe answers with a one-cycle `probe_ack`, with `probe_hit` showing whether the line was resident. If the line was dirty, it is written back first. This happens with `cache_dis` high or low.
- R8: A probe with `probe_inv`=1 leaves the line not resident. A probe with `probe_inv`=0 leaves it resident and clean, so that a later load hits with no memory traffic.
- R9: A flush writes back every dirty line, in any order, leaves every line invalid, and ends with a one-cycle `flush_done`.
- R10: The memory port holds `mem_req`, `mem_we`, `mem_line` and `mem_addr` stable until the cycle `mem_ack` is seen. It issues only the transactions that R2 and R4 to R9 call for.
- R11: Requests pending together while the controller is idle are taken in the order probe, flush, processor. At most one of `cpu_ack`, `probe_ack` and `flush_done` is high in any cycle.
- R12: After reset, all lines are invalid and `cpu_ack`, `probe_ack`, `flush_done` and `mem_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cache_dis | input | 1 | Cache disable: bypass, invalidate on hit, no fill |
| cpu_req | input | 1 | Processor request, held until `cpu_ack` |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 32 | Word-aligned byte address |
| cpu_wdata | input | 32 | Store data |
| cpu_ack | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 32 | Load data, valid with `cpu_ack` |
| probe_req | input | 1 | Coherence probe, held until `probe_ack` |
| probe_addr | input | 32 | Probed address |
| probe_inv | input | 1 | Probe on behalf of a write or exclusive read |
| probe_ack | output | 1 | One-cycle probe completion pulse |
| probe_hit | output | 1 | Line was resident, valid with `probe_ack` |
| flush_req | input | 1 | Flush command, held until `flush_done` |
| flush_done | output | 1 | One-cycle flush completion pulse |
| mem_req | output | 1 | Memory request, held until `mem_ack` |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_line | output | 1 | 1 = whole line, 0 = single word |
| mem_addr | output | 32 | Line-aligned or word address |
| mem_wdata | output | 512 | Write data (word in bits 31:0 for word writes) |
| mem_ack | input | 1 | One-cycle memory completion |
| mem_rdata | input | 512 | Read data (word in bits 31:0 for word reads) |

## Verification
The hardest situation to reach is a dirty line that is still resident at the moment the disable input rises. That state is what separates R4 from R5 and R6.

The stimulus builds it explicitly, with caching enabled:

- It first stores to chosen lines so that they are dirty.
- It uses probes without invalidation to turn other lines clean but still resident.
- Only then does it raise `cache_dis` and revisit each line.

A second hard case is a probe and a processor request to the same line arriving in the same cycle. The bench raises both together and expects the probe's write-back and invalidation to come first. The processor load must then refetch the line.

// File: rtl/nofill_dcache.sv
module nofill_dcache #(
  parameter int ADDR_W     = 32,
  parameter int WORD_W     = 32,
  parameter int LINE_BYTES = 64,
  parameter int SETS       = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cache_dis,
  input  logic                      cpu_req,
  input  logic                      cpu_we,
  input  logic [ADDR_W-1:0]         cpu_addr,
  input  logic [WORD_W-1:0]         cpu_wdata,
  output logic                      cpu_ack,
  output logic [WORD_W-1:0]         cpu_rdata,
  input  logic                      probe_req,
  input  logic [ADDR_W-1:0]         probe_addr,
  input  logic                      probe_inv,
  output logic                      probe_ack,
  output logic                      probe_hit,
  input  logic                      flush_req,
  output logic                      flush_done,
  output logic                      mem_req,
  output logic                      mem_we,
  output logic                      mem_line,
  output logic [ADDR_W-1:0]         mem_addr,
  output logic [LINE_BYTES*8-1:0]   mem_wdata,
  input  logic                      mem_ack,
  input  logic [LINE_BYTES*8-1:0]   mem_rdata
);
  localparam int LINE_W = LINE_BYTES * 8;
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int IDX_W  = $clog2(SETS);
  localparam int TAG_W  = ADDR_W - OFF_W - IDX_W;
  localparam int BSEL_W = $clog2(WORD_W / 8);
  localparam int WSEL_W = OFF_W - BSEL_W;
  localparam int WAYS   = 2;
  localparam logic [IDX_W-1:0] ONE_IDX  = 1;
  localparam logic [IDX_W-1:0] LAST_SET = IDX_W'(SETS - 1);

  localparam logic [2:0] LS_I = 3'd0, LS_S = 3'd1, LS_E = 3'd2, LS_O = 3'd3, LS_M = 3'd4;

  typedef enum logic [3:0] {
    S_IDLE, S_LOOK, S_WB, S_FILL, S_UNC, S_PROBE, S_PWB, S_FLSCAN, S_FLWB
  } fsm_t;

  fsm_t st;
  logic [TAG_W-1:0]  tag_q [WAYS][SETS];
  logic [2:0]        ls_q  [WAYS][SETS];
  logic [LINE_W-1:0] dat_q [WAYS][SETS];
  logic [SETS-1:0]   lru_q;

  logic [ADDR_W-1:0] a_q;
  logic [WORD_W-1:0] wd_q;
  logic              we_q, inv_q, byp_q, way_q, fway_q;
  logic [IDX_W-1:0]  fset_q;

  wire [IDX_W-1:0]  idx  = a_q[OFF_W +: IDX_W];
  wire [TAG_W-1:0]  tag  = a_q[ADDR_W-1 -: TAG_W];
  wire [WSEL_W-1:0] wsel = a_q[BSEL_W +: WSEL_W];

  wire hit0    = ls_q[0][idx] != LS_I && tag_q[0][idx] == tag;
  wire hit1    = ls_q[1][idx] != LS_I && tag_q[1][idx] == tag;
  wire hit     = hit0 | hit1;
  wire hit_way = hit1;
  wire hit_dirty = ls_q[hit_way][idx] == LS_M || ls_q[hit_way][idx] == LS_O;
  wire vic_way = (ls_q[0][idx] == LS_I) ? 1'b0 : (ls_q[1][idx] == LS_I) ? 1'b1 : lru_q[idx];
  wire vic_dirty = ls_q[vic_way][idx] == LS_M || ls_q[vic_way][idx] == LS_O;

  wire             in_fl   = st == S_FLSCAN || st == S_FLWB;
  wire [IDX_W-1:0] cur_set = in_fl ? fset_q : idx;
  wire             cur_way = in_fl ? fway_q : way_q;
  wire fl_dirty = ls_q[fway_q][fset_q] == LS_M || ls_q[fway_q][fset_q] == LS_O;
  wire fl_last  = fway_q && fset_q == LAST_SET;
  wire [ADDR_W-1:0] wb_addr = {tag_q[cur_way][cur_set], cur_set, {OFF_W{1'b0}}};

  assign mem_req   = st == S_WB || st == S_FILL || st == S_UNC || st == S_PWB || st == S_FLWB;
  assign mem_line  = st != S_UNC;
  assign mem_we    = !(st == S_FILL || (st == S_UNC && !we_q));
  assign mem_addr  = (st == S_FILL) ? {tag, idx, {OFF_W{1'b0}}} : (st == S_UNC) ? a_q : wb_addr;
  assign mem_wdata = (st == S_UNC) ? {{(LINE_W-WORD_W){1'b0}}, wd_q} : dat_q[cur_way][cur_set];

  logic [LINE_W-1:0] fill_line;
  always_comb begin
    fill_line = mem_rdata;
    if (we_q) fill_line[wsel*WORD_W +: WORD_W] = wd_q;
  end

  always_ff @(posedge clk) begin
    if (st == S_LOOK && !cache_dis && hit && we_q)
      dat_q[hit_way][idx][wsel*WORD_W +: WORD_W] <= wd_q;
    else if (st == S_FILL && mem_ack)
      dat_q[way_q][idx] <= fill_line;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      for (int w = 0; w < WAYS; w++)
        for (int s = 0; s < SETS; s++) begin
          ls_q[w][s]  <= LS_I;
          tag_q[w][s] <= '0;
        end
      lru_q <= '0;
      a_q <= '0; wd_q <= '0; we_q <= 1'b0; inv_q <= 1'b0; byp_q <= 1'b0;
      way_q <= 1'b0; fway_q <= 1'b0; fset_q <= '0;
      cpu_ack <= 1'b0; cpu_rdata <= '0; probe_ack <= 1'b0; probe_hit <= 1'b0; flush_done <= 1'b0;
    end else begin
      cpu_ack <= 1'b0; probe_ack <= 1'b0; flush_done <= 1'b0;
      case (st)
        S_IDLE:
          if (probe_req) begin
            a_q <= probe_addr; inv_q <= probe_inv; st <= S_PROBE;
          end else if (flush_req) begin
            fset_q <= '0; fway_q <= 1'b0; st <= S_FLSCAN;
          end else if (cpu_req) begin
            a_q <= cpu_addr; we_q <= cpu_we; wd_q <= cpu_wdata; st <= S_LOOK;
          end
        S_LOOK: begin
          byp_q <= cache_dis;
          if (!cache_dis) begin
            if (hit) begin
              cpu_rdata <= dat_q[hit_way][idx][wsel*WORD_W +: WORD_W];
              if (we_q) ls_q[hit_way][idx] <= LS_M;
              lru_q[idx] <= ~hit_way;
              cpu_ack <= 1'b1;
              st <= S_IDLE;
            end else begin
              way_q <= vic_way;
              st <= vic_dirty ? S_WB : S_FILL;
            end
          end else if (hit) begin
            way_q <= hit_way;
            if (hit_dirty) st <= S_WB;
            else begin
              ls_q[hit_way][idx] <= LS_I;
              st <= S_UNC;
            end
          end else st <= S_UNC;
        end
        S_WB:
          if (mem_ack) begin
            if (byp_q) begin
              ls_q[way_q][idx] <= LS_I;
              st <= S_UNC;
            end else st <= S_FILL;
          end
        S_FILL:
          if (mem_ack) begin
            tag_q[way_q][idx] <= tag;
            ls_q[way_q][idx]  <= we_q ? LS_M : LS_E;
            lru_q[idx] <= ~way_q;
            cpu_rdata <= fill_line[wsel*WORD_W +: WORD_W];
            cpu_ack <= 1'b1;
            st <= S_IDLE;
          end
        S_UNC:
          if (mem_ack) begin
            cpu_rdata <= mem_rdata[WORD_W-1:0];
            cpu_ack <= 1'b1;
            st <= S_IDLE;
          end
        S_PROBE:
          if (hit && hit_dirty) begin
            way_q <= hit_way; st <= S_PWB;
          end else begin
            if (hit) ls_q[hit_way][idx] <= inv_q ? LS_I : LS_S;
            probe_hit <= hit; probe_ack <= 1'b1; st <= S_IDLE;
          end
        S_PWB:
          if (mem_ack) begin
            ls_q[way_q][idx] <= inv_q ? LS_I : LS_S;
            probe_hit <= 1'b1; probe_ack <= 1'b1; st <= S_IDLE;
          end
        S_FLSCAN, S_FLWB:
          if ((st == S_FLSCAN && !fl_dirty) || (st == S_FLWB && mem_ack)) begin
            ls_q[fway_q][fset_q] <= LS_I;
            if (fl_last) begin
              flush_done <= 1'b1; st <= S_IDLE;
            end else begin
              st <= S_FLSCAN;
              fway_q <= ~fway_q;
              if (fway_q) fset_q <= fset_q + ONE_IDX;
            end
          end else if (st == S_FLSCAN) st <= S_FLWB;
        default: st <= S_IDLE;
      endcase
    end
  end

  logic any_valid;
  always_comb begin
    any_valid = 1'b0;
    for (int w = 0; w < WAYS; w++)
      for (int s = 0; s < SETS; s++)
        if (ls_q[w][s] != LS_I) any_valid = 1'b1;
  end

  p_mem_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_line));
  p_nofill_r6: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_LOOK && cache_dis |=> !(mem_req && mem_line && !mem_we));
  p_word_only_bypass_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_line |-> byp_q);
  p_flush_clean_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flush_done |-> !any_valid);
  p_one_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cpu_ack, probe_ack, flush_done}));
  p_probe_first_r11: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_IDLE && probe_req |=> st == S_PROBE);
endmodule

// File: tb/nofill_dcache_test.sv
module nofill_dcache_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cache_dis = 1'b0;
  logic cpu_req = 1'b0, cpu_we = 1'b0;
  logic [31:0] cpu_addr = '0, cpu_wdata = '0;
  logic cpu_ack;
  logic [31:0] cpu_rdata;
  logic probe_req = 1'b0, probe_inv = 1'b0;
  logic [31:0] probe_addr = '0;
  logic probe_ack, probe_hit;
  logic flush_req = 1'b0;
  logic flush_done;
  logic mem_req, mem_we, mem_line;
  logic [31:0] mem_addr;
  logic [511:0] mem_wdata;
  logic mem_ack = 1'b0;
  logic [511:0] mem_rdata = '0;

  nofill_dcache uut (
    .clk(clk), .rst_n(rst_n), .cache_dis(cache_dis),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_ack(cpu_ack), .cpu_rdata(cpu_rdata),
    .probe_req(probe_req), .probe_addr(probe_addr), .probe_inv(probe_inv),
    .probe_ack(probe_ack), .probe_hit(probe_hit),
    .flush_req(flush_req), .flush_done(flush_done),
    .mem_req(mem_req), .mem_we(mem_we), .mem_line(mem_line), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata));

  always #10 clk = ~clk;

  int checks = 0, fails = 0, wcnt = 0;
  logic [31:0] mem_img [int];
  logic [31:0] ref_val [int];
  int exp_k[$];
  int exp_a[$];
  bit unordered = 1'b0;
  int m_line [16][2];
  bit m_dirty [16][2];
  int m_cnt [16];

  function automatic logic [31:0] init_val(int wa);
    return (32'(wa) * 32'h9E37_79B1) ^ 32'h5A5A_0000;
  endfunction
  function automatic logic [31:0] mem_rd(int wa);
    return mem_img.exists(wa) ? mem_img[wa] : init_val(wa);
  endfunction
  function automatic logic [31:0] ref_rd(int wa);
    return ref_val.exists(wa) ? ref_val[wa] : init_val(wa);
  endfunction

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic finish_run;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  function automatic int m_find(int line);
    int s = line % 16;
    for (int i = 0; i < m_cnt[s]; i++) if (m_line[s][i] == line) return i;
    return -1;
  endfunction
  function automatic void m_remove(int s, int k);
    if (k == 0 && m_cnt[s] == 2) begin
      m_line[s][0] = m_line[s][1]; m_dirty[s][0] = m_dirty[s][1];
    end
    m_cnt[s]--;
  endfunction
  function automatic void m_front(int s, int line, bit d);
    m_line[s][1] = m_line[s][0]; m_dirty[s][1] = m_dirty[s][0];
    m_line[s][0] = line; m_dirty[s][0] = d;
    m_cnt[s]++;
  endfunction
  function automatic void expect_op(int k, int a);
    exp_k.push_back(k); exp_a.push_back(a);
  endfunction

  // memory responder: kinds 0 line write, 1 line read, 2 word read, 3 word write
  task automatic serve_mem;
    int kind = mem_line ? (mem_we ? 0 : 1) : (mem_we ? 3 : 2);
    int a = int'(mem_addr);
    int at = -1;
    int bad = -1;
    for (int i = 0; i < exp_k.size(); i++)
      if (at < 0 && exp_k[i] == kind && exp_a[i] == a && (unordered || i == 0)) at = i;
    chk(at >= 0, "R10 memory op", 32'(kind), (exp_k.size() > 0) ? 32'(exp_k[0]) : 32'hFFFF_FFFF);
    if (at >= 0) begin exp_k.delete(at); exp_a.delete(at); end
    case (kind)
      0: begin
        for (int w = 0; w < 16; w++) begin
          if (mem_wdata[w*32 +: 32] != ref_rd(a/4 + w)) bad = w;
          mem_img[a/4 + w] = mem_wdata[w*32 +: 32];
        end
        chk(bad < 0, "R2 write-back data", (bad < 0) ? 32'h0 : mem_wdata[bad*32 +: 32],
            (bad < 0) ? 32'h0 : ref_rd(a/4 + bad));
      end
      1: for (int w = 0; w < 16; w++) mem_rdata[w*32 +: 32] = mem_rd(a/4 + w);
      2: mem_rdata = {480'b0, mem_rd(a/4)};
      default: mem_img[a/4] = mem_wdata[31:0];
    endcase
  endtask

  always @(negedge clk) begin
    if (mem_ack) mem_ack = 1'b0;
    else if (mem_req) begin
      wcnt++;
      if (wcnt >= 2) begin wcnt = 0; serve_mem(); mem_ack = 1'b1; end
    end else wcnt = 0;
  end

  task automatic plan_cpu(input bit we, input int addr);
    int line = addr / 64;
    int s = line % 16;
    int k = m_find(line);
    if (!cache_dis) begin
      if (k >= 0) begin
        bit d = m_dirty[s][k] | we;
        m_remove(s, k); m_front(s, line, d);
      end else begin
        if (m_cnt[s] == 2) begin
          if (m_dirty[s][1]) expect_op(0, m_line[s][1] * 64);
          m_cnt[s] = 1;
        end
        expect_op(1, line * 64);
        m_front(s, line, we);
      end
    end else begin
      if (k >= 0) begin
        if (m_dirty[s][k]) expect_op(0, line * 64);
        m_remove(s, k);
      end
      expect_op(we ? 3 : 2, addr);
    end
  endtask

  task automatic cpu_op(input bit we, input int addr, input logic [31:0] wd, input string rq);
    logic [31:0] exp = ref_rd(addr / 4);
    plan_cpu(we, addr);
    cpu_we = we; cpu_addr = 32'(addr); cpu_wdata = wd; cpu_req = 1'b1;
    @(negedge clk);
    while (!cpu_ack) @(negedge clk);
    cpu_req = 1'b0;
    if (we) ref_val[addr / 4] = wd;
    else chk(cpu_rdata == exp, {rq, " load data"}, cpu_rdata, exp);
    chk(exp_k.size() == 0, {rq, " memory ops issued"}, 32'(exp_k.size()), 32'h0);
  endtask

  task automatic plan_probe(input int addr, input bit inv, output bit hit);
    int line = addr / 64;
    int s = line % 16;
    int k = m_find(line);
    hit = k >= 0;
    if (hit) begin
      if (m_dirty[s][k]) expect_op(0, line * 64);
      if (inv) m_remove(s, k); else m_dirty[s][k] = 1'b0;
    end
  endtask

  task automatic probe_op(input int addr, input bit inv, input string rq);
    bit eh;
    plan_probe(addr, inv, eh);
    probe_addr = 32'(addr); probe_inv = inv; probe_req = 1'b1;
    @(negedge clk);
    while (!probe_ack) @(negedge clk);
    probe_req = 1'b0;
    chk(probe_hit == eh, {rq, " probe_hit"}, 32'(probe_hit), 32'(eh));
    chk(exp_k.size() == 0, {rq, " probe memory ops"}, 32'(exp_k.size()), 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    for (int s = 0; s < 16; s++) m_cnt[s] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk({cpu_ack, probe_ack, flush_done, mem_req} == 4'b0, "R12 reset outputs",
        {28'b0, cpu_ack, probe_ack, flush_done, mem_req}, 32'h0);

    cpu_op(1'b0, 0, '0, "R2 cold miss");
    cpu_op(1'b0, 4, '0, "R1 read hit");
    cpu_op(1'b1, 12, 32'hCAFE_0001, "R1 write hit");
    cpu_op(1'b0, 12, '0, "R1 read after write");
    cpu_op(1'b0, 1024, '0, "R3 fill invalid way");
    cpu_op(1'b0, 2056, '0, "R3 evict lru dirty");
    cpu_op(1'b0, 12, '0, "R2 refetch after write-back");
    cpu_op(1'b1, 3080, 32'hBEEF_0002, "R2 write allocate");
    cpu_op(1'b0, 3080, '0, "R2 merged word");

    probe_op(3072, 1'b0, "R7 dirty probe keep");
    cpu_op(1'b0, 3084, '0, "R8 kept line hits");
    probe_op(0, 1'b1, "R8 invalidating probe");
    mem_img[3] = 32'h1234_5678; ref_val[3] = 32'h1234_5678;
    cpu_op(1'b0, 12, '0, "R8 refetch after invalidation");
    probe_op(99 * 64, 1'b0, "R7 probe miss");

    cpu_op(1'b1, 64, 32'hD1D1_0003, "R2 dirty line set1");
    cpu_op(1'b1, 136, 32'hD2D2_0004, "R2 dirty line set2");
    @(negedge clk); cache_dis = 1'b1;
    cpu_op(1'b0, 64, '0, "R4 disabled dirty hit");
    cpu_op(1'b0, 64, '0, "R6 disabled miss after invalidate");
    cpu_op(1'b0, 3072, '0, "R5 disabled clean hit");
    cpu_op(1'b0, 3072, '0, "R6 disabled no fill");
    cpu_op(1'b1, 448, 32'hF00D_0005, "R6 disabled store");
    cpu_op(1'b0, 448, '0, "R6 disabled load back");
    probe_op(128, 1'b0, "R7 probe while disabled");
    @(negedge clk); cache_dis = 1'b0;

    cpu_op(1'b1, 192, 32'hA0A0_0006, "R9 prep");
    cpu_op(1'b1, 1216, 32'hA1A1_0007, "R9 prep");
    cpu_op(1'b1, 260, 32'hA2A2_0008, "R9 prep");
    unordered = 1'b1;
    for (int s = 0; s < 16; s++) begin
      for (int i = 0; i < m_cnt[s]; i++) if (m_dirty[s][i]) expect_op(0, m_line[s][i] * 64);
      m_cnt[s] = 0;
    end
    flush_req = 1'b1;
    @(negedge clk);
    while (!flush_done) @(negedge clk);
    flush_req = 1'b0;
    unordered = 1'b0;
    chk(exp_k.size() == 0, "R9 flush write-backs", 32'(exp_k.size()), 32'h0);
    cpu_op(1'b0, 192, '0, "R9 line invalid after flush");
    cpu_op(1'b0, 128, '0, "R9 clean line invalid after flush");

    cpu_op(1'b1, 320, 32'h5555_0009, "R11 prep");
    begin
      bit eh;
      plan_probe(320, 1'b1, eh);
      plan_cpu(1'b0, 320);
      cpu_we = 1'b0; cpu_addr = 32'd320; cpu_req = 1'b1;
      probe_addr = 32'd320; probe_inv = 1'b1; probe_req = 1'b1;
      @(negedge clk);
      while (!probe_ack && !cpu_ack) @(negedge clk);
      chk(probe_ack && !cpu_ack, "R11 probe served first", {30'b0, probe_ack, cpu_ack}, 32'h2);
      chk(probe_hit == eh, "R11 probe_hit", 32'(probe_hit), 32'(eh));
      probe_req = 1'b0;
      while (!cpu_ack) @(negedge clk);
      cpu_req = 1'b0;
      chk(cpu_rdata == 32'h5555_0009, "R11 load after probe", cpu_rdata, 32'h5555_0009);
      chk(exp_k.size() == 0, "R11 memory ops", 32'(exp_k.size()), 32'h0);
    end
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule